// File: doc/BRIEF.md
# Event Code Matcher with Interrupt Channels

This block watches a stream of already-decoded 8-bit timing event codes. Each code arriving with its valid strobe is compared in parallel against sixteen programmable code slots. Every code value ever received also sets its own bit in a 256-bit seen map, which the host reads as sixteen 16-bit words and clears bit by bit.

Two interrupt channels each pick their trigger from an enumerated list of timing conditions. Nine of these arrive as single-cycle pulses on an input vector, and one is the internal code-match result. Each channel has a status/ID register holding a vector, a level, an enable, a pending bit, a flag bit and two auto-clear controls. The pending bit drives the interrupt request output. The code of the most recent event that raised a code-match interrupt is kept for the host to read.

Configuration and readback use a simple register port: a one-cycle write strobe and a combinational read.

Top module: `evt_irq_core`

## Requirements
- R1: After reset every register reads zero and both interrupt requests are low.
- R2: A valid event whose code equals any of the sixteen slot codes (word addresses 0x00..0x0F, code in bits 7:0) is a code match. On a channel that selects source 10 and is enabled, the match makes its `irq_req` bit high in the cycle after the event.
- R3: A valid event with code C sets bit C[3:0] of seen word 0x10+C[7:4] in the following cycle. Writing a 1 to a seen bit clears it. When an event sets a bit in the same cycle as a clear of that bit, the set wins.
- R4: The select register (0x20 for channel 0, 0x21 for channel 1, bits 3:0) chooses the trigger. Value 0 means none. Values 1..9 select `timing_cond[value-1]`: start, revolution, type match, turn-counter output, delay enabled, delay trigger, delay terminal count, turn-counter trigger, periodic. Value 10 selects code match. Values 11..15 never trigger.
- R5: The status/ID register (0x28 for channel 0, 0x29 for channel 1) has vector in bits 7:0, level in 10:8, enable in 11, pending in 12 (read-only), flag in 13, flag auto-clear in 14 and pending auto-clear in 15. A trigger sets pending only when enable is 1.
- R6: With pending auto-clear set, `irq_ack` for the channel clears pending in the next cycle. With it clear, acknowledge leaves pending set.
- R7: Writing the control word (0x31) with bit k set clears channel k's pending bit.
- R8: A trigger arriving in the same cycle as an acknowledge or a control clear leaves pending set.
- R9: The last-event register (0x30, bits 7:0) takes the event code whenever a code match sets pending on either channel. It keeps its value for any other event or trigger.
- R10: The flag bit sets on every trigger of its channel, whether or not the channel is enabled. Writing 1 to bit 13 clears it. With flag auto-clear set, an acknowledge also clears it.
- R11: The two channels are independent: clearing, acknowledging or reprogramming one leaves the other's state unchanged.
- R12: Addresses outside the map read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_valid | input | 1 | Decoded event present this cycle |
| evt_code | input | 8 | Decoded event code |
| timing_cond | input | 9 | Timing condition pulses, selectable as sources 1..9 |
| irq_ack | input | 2 | Per-channel interrupt acknowledge |
| irq_req | output | 2 | Per-channel interrupt request (pending bit) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register write word address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 6 | Register read word address |
| rd_data | output | 16 | Combinational read data |

## Verification
The hardest situations to reach are same-cycle collisions. These include a new trigger landing together with an acknowledge or a control clear, and an event setting a seen bit while the host clears that same bit. Random stimulus draws event codes mostly from a small pool that the slot writes also use, so matches, repeated codes and seen-bit collisions are frequent. Acknowledges, clears and status rewrites are issued independently in the same cycles. Directed cases force each collision explicitly and check the result against fixed values.

// File: rtl/evt_irq_pkg.sv
`timescale 1ns/1ps
// Package: shared register map, source encodings and status layout for the
// event code matcher. Assumes at most eight interrupt channels (map spacing).
package evt_irq_pkg;

    localparam int ADDR_W = 6;
    localparam int REG_W  = 16;
    localparam int SEL_W  = 4;
    localparam int NUM_COND = 9;   // sources 1..9 come from timing pulses

    // Interrupt trigger selection values
    typedef enum logic [SEL_W-1:0] {
        SRC_NULL         = 4'd0,
        SRC_START        = 4'd1,
        SRC_REVOLUTION   = 4'd2,
        SRC_TYPE_MATCH   = 4'd3,
        SRC_TURN_OUT     = 4'd4,
        SRC_DLY_ENABLED  = 4'd5,
        SRC_DLY_TRIGGER  = 4'd6,
        SRC_DLY_TERMINAL = 4'd7,
        SRC_TURN_TRIGGER = 4'd8,
        SRC_PERIODIC     = 4'd9,
        SRC_CODE_MATCH   = 4'd10
    } src_sel_e;

    // Status/ID register layout, MSB first
    typedef struct packed {
        logic       pend_autoclr;
        logic       flag_autoclr;
        logic       flag;
        logic       pending;
        logic       enable;
        logic [2:0] level;
        logic [7:0] vector;
    } irq_stat_t;

    localparam int ST_FLAG_BIT = 13;

    // Word address map
    localparam logic [ADDR_W-1:0] A_CODE_BASE = 6'h00;
    localparam logic [ADDR_W-1:0] A_SEEN_BASE = 6'h10;
    localparam logic [ADDR_W-1:0] A_SEL_BASE  = 6'h20;
    localparam logic [ADDR_W-1:0] A_STAT_BASE = 6'h28;
    localparam logic [ADDR_W-1:0] A_LAST      = 6'h30;
    localparam logic [ADDR_W-1:0] A_CTRL      = 6'h31;

endpackage

// File: rtl/evt_code_cmp.sv
`timescale 1ns/1ps
// Module: evt_code_cmp
// Holds NUM_CODES programmable code slots and compares every valid event
// against all of them in parallel. Assumes the write index is already
// decoded by the parent; the hit output is combinational from the inputs.
module evt_code_cmp #(
    parameter int NUM_CODES = 16,
    parameter int CODE_W    = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [$clog2(NUM_CODES)-1:0]  wr_idx,
    input  logic [CODE_W-1:0]             wr_code,
    input  logic                          evt_valid,
    input  logic [CODE_W-1:0]             evt_code,
    output logic                          hit,
    output logic [NUM_CODES*CODE_W-1:0]   codes_flat
);
    localparam int IDX_W = $clog2(NUM_CODES);

    logic [NUM_CODES-1:0] slot_hit;

    for (genvar g = 0; g < NUM_CODES; g++) begin : g_slot
        logic [CODE_W-1:0] code_q;

        // Slot register: load on a write addressed to this slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                code_q <= '0;
            else if (wr_en && (wr_idx == IDX_W'(g)))
                code_q <= wr_code;
        end

        assign slot_hit[g] = evt_valid && (code_q == evt_code);
        assign codes_flat[g*CODE_W +: CODE_W] = code_q;
    end

    // Any slot equal to the current event is a match
    always_comb hit = |slot_hit;

endmodule

// File: rtl/evt_seen_map.sv
`timescale 1ns/1ps
// Module: evt_seen_map
// One sticky bit per possible event code, grouped into WORD_W-bit words by
// the upper code bits. The host clears bits by writing ones; a same-cycle
// event on a bit being cleared keeps that bit set.
module evt_seen_map #(
    parameter int CODE_W = 8,
    parameter int WORD_W = 16
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic                                        evt_valid,
    input  logic [CODE_W-1:0]                           evt_code,
    input  logic                                        clr_en,
    input  logic [$clog2((2**CODE_W)/WORD_W)-1:0]       clr_word,
    input  logic [WORD_W-1:0]                           clr_mask,
    output logic [(2**CODE_W)-1:0]                      seen
);
    localparam int NUM_BITS  = 2**CODE_W;
    localparam int NUM_WORDS = NUM_BITS / WORD_W;
    localparam int WIDX_W    = $clog2(NUM_WORDS);
    localparam int LO_W      = $clog2(WORD_W);

    logic [WIDX_W-1:0] evt_word;
    logic [LO_W-1:0]   evt_bit;

    // Split the code into word index and bit-within-word
    always_comb begin
        evt_word = evt_code[CODE_W-1:LO_W];
        evt_bit  = evt_code[LO_W-1:0];
    end

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        logic [WORD_W-1:0] set_v;
        logic [WORD_W-1:0] clr_v;
        logic [WORD_W-1:0] word_q;

        // Per-word set and clear masks for this cycle
        always_comb begin
            set_v = '0;
            if (evt_valid && (evt_word == WIDX_W'(w)))
                set_v[evt_bit] = 1'b1;
            clr_v = (clr_en && (clr_word == WIDX_W'(w))) ? clr_mask : '0;
        end

        // Word register: clear first, then set so a new event wins
        always_ff @(posedge clk) begin
            if (!rst_n)
                word_q <= '0;
            else
                word_q <= (word_q & ~clr_v) | set_v;
        end

        assign seen[w*WORD_W +: WORD_W] = word_q;
    end

endmodule

// File: rtl/evt_irq_chan.sv
`timescale 1ns/1ps
// Module: evt_irq_chan
// One interrupt channel: trigger select register, status/ID register and
// the pending and flag state. A trigger in the same cycle as any clear
// wins. Assumes write strobes are decoded and single-cycle.
module evt_irq_chan
    import evt_irq_pkg::*;
#(
    parameter int N_COND = NUM_COND
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_COND-1:0]   cond,
    input  logic                code_hit,
    input  logic                sel_we,
    input  logic                st_we,
    input  logic [REG_W-1:0]    wdata,
    input  logic                clr_req,
    input  logic                ack,
    output logic [SEL_W-1:0]    sel_q,
    output logic [REG_W-1:0]    stat_rd,
    output logic                src_fire,
    output logic                code_irq,
    output logic                irq
);
    logic [7:0] vector_q;
    logic [2:0] level_q;
    logic       enable_q;
    logic       pending_q;
    logic       flag_q;
    logic       flag_ac_q;
    logic       pend_ac_q;
    logic       set_pend;
    logic       unused_wbit;
    irq_stat_t  stat;

    // Pending is read-only through the write path
    assign unused_wbit = wdata[12];

    // Trigger multiplexer: null, timing pulses 1..N_COND, or code match
    always_comb begin
        src_fire = 1'b0;
        if (sel_q == SRC_CODE_MATCH)
            src_fire = code_hit;
        else
            for (int k = 0; k < N_COND; k++)
                if (sel_q == SEL_W'(k + 1))
                    src_fire = cond[k];
    end

    // A trigger only requests service when the channel is enabled
    always_comb begin
        set_pend = src_fire && enable_q;
        code_irq = set_pend && (sel_q == SRC_CODE_MATCH);
    end

    // Trigger select register
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= '0;
        else if (sel_we)
            sel_q <= wdata[SEL_W-1:0];
    end

    // Host-writable status fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vector_q  <= '0;
            level_q   <= '0;
            enable_q  <= 1'b0;
            flag_ac_q <= 1'b0;
            pend_ac_q <= 1'b0;
        end else if (st_we) begin
            vector_q  <= wdata[7:0];
            level_q   <= wdata[10:8];
            enable_q  <= wdata[11];
            flag_ac_q <= wdata[14];
            pend_ac_q <= wdata[15];
        end
    end

    // Pending bit: set by an enabled trigger, cleared by control or auto-clear ack
    always_ff @(posedge clk) begin
        if (!rst_n)
            pending_q <= 1'b0;
        else if (set_pend)
            pending_q <= 1'b1;
        else if (clr_req || (ack && pend_ac_q))
            pending_q <= 1'b0;
    end

    // Flag bit: set by any trigger, cleared by write-one or auto-clear ack
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (src_fire)
            flag_q <= 1'b1;
        else if ((st_we && wdata[ST_FLAG_BIT]) || (ack && flag_ac_q))
            flag_q <= 1'b0;
    end

    // Assemble the readable status word
    always_comb begin
        stat.pend_autoclr = pend_ac_q;
        stat.flag_autoclr = flag_ac_q;
        stat.flag         = flag_q;
        stat.pending      = pending_q;
        stat.enable       = enable_q;
        stat.level        = level_q;
        stat.vector       = vector_q;
        stat_rd           = stat;
        irq               = pending_q;
    end

endmodule

// File: rtl/evt_irq_core.sv
`timescale 1ns/1ps
// Module: evt_irq_core (top)
// Event code matcher with a seen-code map, a last-interrupt-code register
// and NUM_IRQ interrupt channels behind a word-addressed register port.
// Assumes NUM_CODES <= 16, NUM_IRQ <= 8 and the map in evt_irq_pkg.
module evt_irq_core
    import evt_irq_pkg::*;
#(
    parameter int NUM_CODES = 16,
    parameter int CODE_W    = 8,
    parameter int NUM_IRQ   = 2,
    parameter int N_COND    = NUM_COND
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 evt_valid,
    input  logic [CODE_W-1:0]    evt_code,
    input  logic [N_COND-1:0]    timing_cond,
    input  logic [NUM_IRQ-1:0]   irq_ack,
    output logic [NUM_IRQ-1:0]   irq_req,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [REG_W-1:0]     wr_data,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [REG_W-1:0]     rd_data
);
    localparam int IDX_W     = $clog2(NUM_CODES);
    localparam int NUM_BITS  = 2**CODE_W;
    localparam int NUM_WORDS = NUM_BITS / REG_W;
    localparam int WIDX_W    = $clog2(NUM_WORDS);
    localparam logic [ADDR_W-1:0] CODE_END = A_CODE_BASE + ADDR_W'(NUM_CODES);
    localparam logic [ADDR_W-1:0] SEEN_END = A_SEEN_BASE + ADDR_W'(NUM_WORDS);

    logic                          match_hit;
    logic [NUM_CODES*CODE_W-1:0]   codes_flat;
    logic [NUM_BITS-1:0]           seen_flat;
    logic                          code_wr;
    logic                          seen_clr;
    logic [IDX_W-1:0]              code_idx;
    logic [WIDX_W-1:0]             seen_idx;
    logic [NUM_IRQ-1:0]            sel_we;
    logic [NUM_IRQ-1:0]            st_we;
    logic [NUM_IRQ-1:0]            clr_req;
    logic [NUM_IRQ-1:0]            src_fire;
    logic [NUM_IRQ-1:0]            code_irq;
    logic [NUM_IRQ-1:0]            chan_en;
    logic [NUM_IRQ-1:0]            chan_pac;
    logic [NUM_IRQ*SEL_W-1:0]      chan_sel;
    logic [NUM_IRQ*REG_W-1:0]      chan_stat;
    logic [CODE_W-1:0]             last_code;

    // Write address decode into per-target strobes
    always_comb begin
        code_wr  = wr_en && (wr_addr >= A_CODE_BASE) && (wr_addr < CODE_END);
        code_idx = IDX_W'(wr_addr - A_CODE_BASE);
        seen_clr = wr_en && (wr_addr >= A_SEEN_BASE) && (wr_addr < SEEN_END);
        seen_idx = WIDX_W'(wr_addr - A_SEEN_BASE);
        for (int c = 0; c < NUM_IRQ; c++) begin
            sel_we[c]  = wr_en && (wr_addr == A_SEL_BASE  + ADDR_W'(c));
            st_we[c]   = wr_en && (wr_addr == A_STAT_BASE + ADDR_W'(c));
            clr_req[c] = wr_en && (wr_addr == A_CTRL) && wr_data[c];
        end
    end

    evt_code_cmp #(
        .NUM_CODES (NUM_CODES),
        .CODE_W    (CODE_W)
    ) u_cmp (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (code_wr),
        .wr_idx     (code_idx),
        .wr_code    (wr_data[CODE_W-1:0]),
        .evt_valid  (evt_valid),
        .evt_code   (evt_code),
        .hit        (match_hit),
        .codes_flat (codes_flat)
    );

    evt_seen_map #(
        .CODE_W (CODE_W),
        .WORD_W (REG_W)
    ) u_seen (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_valid (evt_valid),
        .evt_code  (evt_code),
        .clr_en    (seen_clr),
        .clr_word  (seen_idx),
        .clr_mask  (wr_data),
        .seen      (seen_flat)
    );

    for (genvar c = 0; c < NUM_IRQ; c++) begin : g_chan
        evt_irq_chan #(
            .N_COND (N_COND)
        ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .cond     (timing_cond),
            .code_hit (match_hit),
            .sel_we   (sel_we[c]),
            .st_we    (st_we[c]),
            .wdata    (wr_data),
            .clr_req  (clr_req[c]),
            .ack      (irq_ack[c]),
            .sel_q    (chan_sel[c*SEL_W +: SEL_W]),
            .stat_rd  (chan_stat[c*REG_W +: REG_W]),
            .src_fire (src_fire[c]),
            .code_irq (code_irq[c]),
            .irq      (irq_req[c])
        );
        assign chan_en[c]  = chan_stat[c*REG_W + 11];
        assign chan_pac[c] = chan_stat[c*REG_W + 15];
    end

    // Last-interrupt code: captured when a code match raises any channel
    always_ff @(posedge clk) begin
        if (!rst_n)
            last_code <= '0;
        else if (|code_irq)
            last_code <= evt_code;
    end

    // Combinational register read multiplexer
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_CODES; i++)
            if (rd_addr == A_CODE_BASE + ADDR_W'(i))
                rd_data = REG_W'(codes_flat[i*CODE_W +: CODE_W]);
        for (int w = 0; w < NUM_WORDS; w++)
            if (rd_addr == A_SEEN_BASE + ADDR_W'(w))
                rd_data = seen_flat[w*REG_W +: REG_W];
        for (int c = 0; c < NUM_IRQ; c++) begin
            if (rd_addr == A_SEL_BASE + ADDR_W'(c))
                rd_data = REG_W'(chan_sel[c*SEL_W +: SEL_W]);
            if (rd_addr == A_STAT_BASE + ADDR_W'(c))
                rd_data = chan_stat[c*REG_W +: REG_W];
        end
        if (rd_addr == A_LAST)
            rd_data = REG_W'(last_code);
    end

endmodule

// File: rtl/evt_irq_chk.sv
`timescale 1ns/1ps
// Module: evt_irq_chk
// Timing checks on the matcher, bound into evt_irq_core. Observes the
// ports plus the per-channel trigger, enable, auto-clear and select state.
module evt_irq_chk #(
    parameter int CODE_W  = 8,
    parameter int NUM_IRQ = 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    evt_valid,
    input logic [CODE_W-1:0]       evt_code,
    input logic [NUM_IRQ-1:0]      irq_req,
    input logic [NUM_IRQ-1:0]      irq_ack,
    input logic [NUM_IRQ-1:0]      src_fire,
    input logic [NUM_IRQ-1:0]      chan_en,
    input logic [NUM_IRQ-1:0]      chan_pac,
    input logic [NUM_IRQ*4-1:0]    chan_sel,
    input logic [CODE_W-1:0]       last_code,
    input logic [(2**CODE_W)-1:0]  seen_flat
);
    // A valid event marks its code as seen in the next cycle
    assert_seen_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |=> seen_flat[$past(evt_code)]);

    // The last-interrupt code only moves on a cycle that carried an event
    assert_last_needs_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(last_code) |-> $past(evt_valid));

    for (genvar c = 0; c < NUM_IRQ; c++) begin : g_chk
        // Request rises only after an enabled trigger
        assert_rise_has_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq_req[c]) |-> $past(src_fire[c] && chan_en[c]));

        // An enabled trigger always yields a request, whatever clears coincide
        assert_trigger_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (src_fire[c] && chan_en[c]) |=> irq_req[c]);

        // Acknowledge with pending auto-clear drops the request
        assert_ack_autoclear_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_req[c] && irq_ack[c] && chan_pac[c] && !(src_fire[c] && chan_en[c]))
            |=> !irq_req[c]);

        // Null selection never triggers
        assert_null_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (chan_sel[c*4 +: 4] == 4'd0) |-> !src_fire[c]);
    end

endmodule

bind evt_irq_core evt_irq_chk #(
    .CODE_W  (CODE_W),
    .NUM_IRQ (NUM_IRQ)
) u_evt_irq_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_valid (evt_valid),
    .evt_code  (evt_code),
    .irq_req   (irq_req),
    .irq_ack   (irq_ack),
    .src_fire  (src_fire),
    .chan_en   (chan_en),
    .chan_pac  (chan_pac),
    .chan_sel  (chan_sel),
    .last_code (last_code),
    .seen_flat (seen_flat)
);

// File: tb/test_evt_irq_core.sv
`timescale 1ns/1ps
// Bench for evt_irq_core: directed corner cases, then seeded random traffic
// compared every cycle against a requirement-level model kept in the bench.
module test_evt_irq_core;

    localparam logic [5:0] A_SEEN = 6'h10;
    localparam logic [5:0] A_SEL0 = 6'h20;
    localparam logic [5:0] A_SEL1 = 6'h21;
    localparam logic [5:0] A_ST0  = 6'h28;
    localparam logic [5:0] A_ST1  = 6'h29;
    localparam logic [5:0] A_LST  = 6'h30;
    localparam logic [5:0] A_CTL  = 6'h31;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_valid = 1'b0;
    logic [7:0]  evt_code = '0;
    logic [8:0]  timing_cond = '0;
    logic [1:0]  irq_ack = '0;
    logic [1:0]  irq_req;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [5:0]  rd_addr = '0;
    logic [15:0] rd_data;

    int n_chk = 0;
    int n_fail = 0;

    // Reference model state
    logic [7:0]   m_code [16];
    logic [255:0] m_seen;
    logic [3:0]   m_sel [2];
    logic [7:0]   m_vec [2];
    logic [2:0]   m_lvl [2];
    logic [1:0]   m_en, m_pend, m_flag, m_fac, m_pac;
    logic [7:0]   m_last;

    evt_irq_core i_evt_irq_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_valid   (evt_valid),
        .evt_code    (evt_code),
        .timing_cond (timing_cond),
        .irq_ack     (irq_ack),
        .irq_req     (irq_req),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data)
    );

    always #5 clk = ~clk;

    function automatic void model_reset();
        for (int i = 0; i < 16; i++) m_code[i] = '0;
        for (int c = 0; c < 2; c++) begin
            m_sel[c] = '0; m_vec[c] = '0; m_lvl[c] = '0;
        end
        m_seen = '0; m_en = '0; m_pend = '0; m_flag = '0;
        m_fac = '0; m_pac = '0; m_last = '0;
    endfunction

    // Next state from the requirements, using current-cycle register values
    function automatic void model_step(logic v, logic [7:0] c, logic [8:0] cond,
                                       logic [1:0] ack, logic we, logic [5:0] wa,
                                       logic [15:0] wd);
        logic       hit;
        logic [1:0] fire;
        logic       setp;
        logic [7:0] nlast;
        hit = 1'b0;
        nlast = m_last;
        for (int i = 0; i < 16; i++) if (v && m_code[i] == c) hit = 1'b1;
        for (int ch = 0; ch < 2; ch++) begin
            if (m_sel[ch] >= 4'd1 && m_sel[ch] <= 4'd9) fire[ch] = cond[m_sel[ch] - 4'd1];
            else if (m_sel[ch] == 4'd10)                fire[ch] = hit;
            else                                        fire[ch] = 1'b0;
            setp = fire[ch] && m_en[ch];
            if (setp) m_pend[ch] = 1'b1;
            else if ((we && wa == A_CTL && wd[ch]) || (ack[ch] && m_pac[ch])) m_pend[ch] = 1'b0;
            if (fire[ch]) m_flag[ch] = 1'b1;
            else if ((we && wa == A_ST0 + 6'(ch) && wd[13]) || (ack[ch] && m_fac[ch])) m_flag[ch] = 1'b0;
            if (setp && m_sel[ch] == 4'd10) nlast = c;
        end
        if (we) begin
            if (wa < 6'h10) m_code[wa[3:0]] = wd[7:0];
            if (wa >= A_SEEN && wa < 6'h20)
                for (int j = 0; j < 16; j++) if (wd[j]) m_seen[{wa[3:0], 4'(j)}] = 1'b0;
            for (int ch = 0; ch < 2; ch++) begin
                if (wa == A_SEL0 + 6'(ch)) m_sel[ch] = wd[3:0];
                if (wa == A_ST0 + 6'(ch)) begin
                    m_vec[ch] = wd[7:0]; m_lvl[ch] = wd[10:8]; m_en[ch] = wd[11];
                    m_fac[ch] = wd[14];  m_pac[ch] = wd[15];
                end
            end
        end
        if (v) m_seen[c] = 1'b1;
        m_last = nlast;
    endfunction

    function automatic logic [15:0] model_rd(logic [5:0] a);
        if (a < 6'h10) return {8'h00, m_code[a[3:0]]};
        if (a < 6'h20) return m_seen[{a[3:0], 4'h0} +: 16];
        if (a == A_SEL0 || a == A_SEL1) return {12'h000, m_sel[a[0]]};
        if (a == A_ST0 || a == A_ST1)
            return {m_pac[a[0]], m_fac[a[0]], m_flag[a[0]], m_pend[a[0]],
                    m_en[a[0]], m_lvl[a[0]], m_vec[a[0]]};
        if (a == A_LST) return {8'h00, m_last};
        return 16'h0000;
    endfunction

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // One clock cycle of stimulus; entered and left at a falling edge
    task automatic cyc(input logic v, input logic [7:0] c, input logic [8:0] cond,
                       input logic [1:0] ack, input logic we, input logic [5:0] wa,
                       input logic [15:0] wd);
        evt_valid = v; evt_code = c; timing_cond = cond; irq_ack = ack;
        wr_en = we; wr_addr = wa; wr_data = wd;
        model_step(v, c, cond, ack, we, wa, wd);
        @(posedge clk);
        #2;
        evt_valid = 1'b0; timing_cond = '0; irq_ack = '0; wr_en = 1'b0;
        chk("R11 irq_req vs model", {14'h0, irq_req}, {14'h0, m_pend});
        @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        cyc(1'b0, 8'h00, 9'h0, 2'b00, 1'b1, a, d);
    endtask

    task automatic rd(input logic [5:0] a, output logic [15:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
        @(negedge clk);
    endtask

    task automatic rd_chk(input string tag, input logic [5:0] a, input logic [15:0] exp);
        logic [15:0] d;
        rd(a, d);
        chk(tag, d, exp);
    endtask

    // Compare every mapped register and two unmapped ones against the model
    task automatic chk_all();
        logic [15:0] d;
        for (int a = 0; a < 16; a++) begin rd(6'(a), d); chk("R2 code slot", d, model_rd(6'(a))); end
        for (int a = 16; a < 32; a++) begin rd(6'(a), d); chk("R3 seen word", d, model_rd(6'(a))); end
        rd(A_SEL0, d); chk("R4 select 0", d, model_rd(A_SEL0));
        rd(A_SEL1, d); chk("R4 select 1", d, model_rd(A_SEL1));
        rd(A_ST0, d);  chk("R5 status 0", d, model_rd(A_ST0));
        rd(A_ST1, d);  chk("R5 status 1", d, model_rd(A_ST1));
        rd(A_LST, d);  chk("R9 last code", d, model_rd(A_LST));
        rd(6'h32, d);  chk("R12 unmapped", d, 16'h0000);
        rd(6'h3F, d);  chk("R12 unmapped", d, 16'h0000);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        #2000000;
        n_fail++;
        $display("FAIL R1 watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] ec;
        logic [15:0] wd;
        logic [5:0] wa;
        logic we;
        void'($urandom(32'h0005eed5));
        model_reset();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1 irq_req after reset", {14'h0, irq_req}, 16'h0000);
        rd_chk("R1 status 0 after reset", A_ST0, 16'h0000);
        rd_chk("R1 last after reset", A_LST, 16'h0000);
        chk_all();

        // R2: code match raises channel 0
        wr(6'h05, 16'h003C);
        wr(A_SEL0, 16'd10);
        wr(A_ST0, 16'h0841);
        cyc(1'b1, 8'h3C, 9'h0, 2'b00, 1'b0, 6'h0, 16'h0);
        chk("R2 match raises irq0", {15'h0, irq_req[0]}, 16'h0001);
        rd_chk("R9 last after match", A_LST, 16'h003C);
        rd_chk("R10 flag and pending set", A_ST0, 16'h3841);

        // R7: control clear
        wr(A_CTL, 16'h0001);
        chk("R7 control clears irq0", {15'h0, irq_req[0]}, 16'h0000);
        rd_chk("R7 flag kept after clear", A_ST0, 16'h2841);

        // R6: acknowledge with and without pending auto-clear
        cyc(1'b1, 8'h3C, 9'h0, 2'b00, 1'b0, 6'h0, 16'h0);
        cyc(1'b0, 8'h00, 9'h0, 2'b01, 1'b0, 6'h0, 16'h0);
        chk("R6 ack without auto-clear holds", {15'h0, irq_req[0]}, 16'h0001);
        wr(A_ST0, 16'h8841);
        cyc(1'b0, 8'h00, 9'h0, 2'b01, 1'b0, 6'h0, 16'h0);
        chk("R6 ack with auto-clear drops", {15'h0, irq_req[0]}, 16'h0000);

        // R8: trigger coinciding with ack or control clear
        cyc(1'b1, 8'h3C, 9'h0, 2'b01, 1'b0, 6'h0, 16'h0);
        chk("R8 trigger with ack sets", {15'h0, irq_req[0]}, 16'h0001);
        cyc(1'b1, 8'h3C, 9'h0, 2'b01, 1'b0, 6'h0, 16'h0);
        chk("R8 trigger with ack holds", {15'h0, irq_req[0]}, 16'h0001);
        cyc(1'b1, 8'h3C, 9'h0, 2'b00, 1'b1, A_CTL, 16'h0001);
        chk("R8 trigger with clear holds", {15'h0, irq_req[0]}, 16'h0001);
        wr(A_CTL, 16'h0001);

        // R5: disabled channel records flag only
        wr(A_SEL1, 16'd1);
        cyc(1'b0, 8'h00, 9'h001, 2'b00, 1'b0, 6'h0, 16'h0);
        chk("R5 disabled channel stays low", {14'h0, irq_req}, 16'h0000);
        rd_chk("R5 flag without enable", A_ST1, 16'h2000);

        // R10: flag write-one clear and acknowledge auto-clear
        wr(A_ST1, 16'h2000);
        rd_chk("R10 flag write-one clear", A_ST1, 16'h0000);
        wr(A_ST1, 16'h4000);
        cyc(1'b0, 8'h00, 9'h001, 2'b00, 1'b0, 6'h0, 16'h0);
        rd_chk("R10 flag set", A_ST1, 16'h6000);
        cyc(1'b0, 8'h00, 9'h000, 2'b10, 1'b0, 6'h0, 16'h0);
        rd_chk("R10 flag auto-clear on ack", A_ST1, 16'h4000);

        // R4: source selection
        wr(A_SEL1, 16'd9);
        wr(A_ST1, 16'h0800);
        cyc(1'b0, 8'h00, 9'h100, 2'b00, 1'b0, 6'h0, 16'h0);
        chk("R4 select 9 uses periodic pulse", {15'h0, irq_req[1]}, 16'h0001);
        wr(A_CTL, 16'h0002);
        cyc(1'b0, 8'h00, 9'h0FF, 2'b00, 1'b0, 6'h0, 16'h0);
        chk("R4 select 9 ignores other pulses", {15'h0, irq_req[1]}, 16'h0000);
        wr(A_SEL1, 16'd12);
        cyc(1'b1, 8'h3C, 9'h1FF, 2'b00, 1'b0, 6'h0, 16'h0);
        chk("R4 select 12 never fires", {15'h0, irq_req[1]}, 16'h0000);
        wr(A_SEL1, 16'd0);
        cyc(1'b1, 8'h3C, 9'h1FF, 2'b00, 1'b0, 6'h0, 16'h0);
        chk("R4 select 0 never fires", {15'h0, irq_req[1]}, 16'h0000);
        wr(A_CTL, 16'h0001);

        // R9: last code updates on code interrupts only
        wr(6'h02, 16'h0077);
        cyc(1'b1, 8'h77, 9'h0, 2'b00, 1'b0, 6'h0, 16'h0);
        rd_chk("R9 last takes new match", A_LST, 16'h0077);
        wr(A_SEL1, 16'd1);
        cyc(1'b0, 8'h00, 9'h001, 2'b00, 1'b0, 6'h0, 16'h0);
        cyc(1'b1, 8'h55, 9'h000, 2'b00, 1'b0, 6'h0, 16'h0);
        rd_chk("R9 last held on other triggers", A_LST, 16'h0077);

        // R11: clearing channel 1 leaves channel 0
        wr(A_CTL, 16'h0002);
        chk("R11 channels independent", {14'h0, irq_req}, 16'h0001);

        // R3: seen map set, collision and clear
        rd_chk("R3 seen 0x3C", A_SEEN + 6'h3, 16'h1000);
        rd_chk("R3 seen 0x55", A_SEEN + 6'h5, 16'h0020);
        cyc(1'b1, 8'h3C, 9'h0, 2'b00, 1'b1, A_SEEN + 6'h3, 16'hFFFF);
        rd_chk("R3 set wins over clear", A_SEEN + 6'h3, 16'h1000);
        wr(A_SEEN + 6'h3, 16'h1000);
        rd_chk("R3 write-one clear", A_SEEN + 6'h3, 16'h0000);

        // R12: unmapped write has no effect
        wr(6'h3A, 16'hFFFF);
        chk_all();

        // Random traffic against the model
        for (int n = 0; n < 3000; n++) begin
            int r;
            we = 1'b0; wa = '0; wd = $urandom;
            if ($urandom % 5 == 0) begin
                we = 1'b1;
                r = $urandom % 10;
                if (r < 3)      begin wa = 6'($urandom % 16); wd = {8'h00, 8'h20 + 8'($urandom % 8)}; end
                else if (r < 5) wa = A_SEEN + 6'($urandom % 16);
                else if (r == 5) begin wa = A_SEL0 + 6'($urandom % 2); wd = 16'($urandom % 12); end
                else if (r < 8) wa = A_ST0 + 6'($urandom % 2);
                else if (r == 8) wa = A_CTL;
                else            wa = 6'h32 + 6'($urandom % 13);
            end
            ec = ($urandom % 2 == 0) ? 8'h20 + 8'($urandom % 8) : 8'($urandom);
            cyc(1'($urandom), ec, 9'($urandom & $urandom & $urandom),
                2'($urandom & $urandom), we, wa, wd);
            if (n % 150 == 149) chk_all();
        end
        chk_all();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule